// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Noise Voting

This block turns an asynchronous serial line into bytes. The idle line sits high. A character opens with a low start bit, carries eight data bits with the least significant bit first, and closes with a high stop bit. The receiver runs from a system clock. A divider, set by a parameter, makes an oversampling tick at sixteen times the bit rate. Each falling edge that opens a character restarts that divider and the tick count, so the bit timing is realigned on every character. This holds even when characters follow each other with no idle time between them.

Each bit is decided by a vote over three ticks around its centre. When the three samples disagree, the character is flagged as noisy. A stop bit that reads low still delivers its byte, but with a framing flag, and the receiver then waits for the line to go high again. Delivery is a single-clock strobe with no back-pressure: the byte and both flags are presented together and held until the next delivery, so a consumer that misses the strobe can still read the last character.

Top module: `serial_rx_vote`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_valid`, `rx_byte`, `rx_frame_err` and `rx_noise_err` are all 0.
- R2: A falling edge starts a character only if the line still reads 0 at tick 8 of the start bit. Otherwise no byte is delivered, and the receiver looks for a new edge.
- R3: The eight data bits are received least significant bit first. `rx_byte` changes only when `rx_valid` is 1.
- R4: Each data bit and the stop bit take the majority value of the samples at ticks 7, 8 and 9 of that bit. A single deviating sample does not change the bit.
- R5: `rx_noise_err` is 1 for a character in which any data bit or the stop bit had disagreeing samples, and 0 otherwise. It changes only when `rx_valid` is 1.
- R6: A stop bit that votes 0 still delivers the byte, with `rx_frame_err` = 1. A stop bit that votes 1 gives `rx_frame_err` = 0. The flag changes only when `rx_valid` is 1.
- R7: After a framing error, no new character starts while the line stays 0. Once the line returns to 1, the next falling edge starts a character.
- R8: `rx_valid` is high for exactly one clock. It is seen 153·CLKS_PER_TICK+3 clocks after the line falls to open the character: two synchroniser stages, one edge-detect cycle, and the vote at tick 9 of the stop bit.
- R9: Characters sent back to back, with the next start bit following the stop bit immediately, are each received correctly and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Last received byte, held between deliveries |
| rx_valid | output | 1 | One-clock strobe: a new byte and its flags are present |
| rx_frame_err | output | 1 | Stop bit of the last character voted 0 |
| rx_noise_err | output | 1 | Samples of some bit in the last character disagreed |

## Verification
The bench drives the following line patterns:
- Clean bytes, including single-bit-set values, which show that the bit order is least significant first.
- One-clock glitches that land on exactly one voting tick of a data bit or of the stop bit. These separate the majority result from the noise flag, and the bench checks that the flag clears again on a clean character.
- A runt low pulse that lasts until just before the start-bit centre. This tells start qualification apart from plain edge triggering.
- A low stop bit followed by a long low break, then recovery. This separates the framing flag from the wait for a high line.
- A burst of characters sent back to back. This shows that the timing is realigned on each start edge.

A behavioural model compares all outputs on every clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_HOLD  = 3'd4
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
// Synchroniser chain on the raw input; also exposes the stage after it
// so the caller can detect edges on clean, synchronised values.
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic dout_prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign dout      = chain[STAGES-1];
  assign dout_prev = chain[STAGES];
endmodule

// File: rtl/srx_tick.sv
// Oversampling tick divider, restarted by clr.
module srx_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1)) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srx_vote.sv
// Keeps the samples of the two ticks before the last voting tick and
// forms the three-way majority and disagreement with the live sample.
module srx_vote #(
  parameter int OSR = 16,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [PW-1:0] pos_in,
  input  logic          line,
  output logic          decide,
  output logic          maj,
  output logic          dis
);
  localparam int MID = OSR / 2;
  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (pos_in == PW'(MID - 1)) s_a <= line;
      if (pos_in == PW'(MID))     s_b <= line;
    end
  end

  assign decide = tick && (pos_in == PW'(MID + 1));
  assign maj    = (s_a & s_b) | (s_a & line) | (s_b & line);
  assign dis    = !((s_a == s_b) && (s_b == line));
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote #(
  parameter int CLKS_PER_TICK = 4,
  parameter int OSR           = 16,
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_frame_err,
  output logic                 rx_noise_err
);
  import srx_pkg::*;

  localparam int MID = OSR / 2;
  localparam int PW  = $clog2(OSR + 1);
  localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  srx_state_e           state;
  logic                 line_s, line_p, fall;
  logic                 tick, start_go;
  logic [PW-1:0]        pos, pos_next;
  logic                 wrap;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 noise_acc;
  logic                 decide, maj, dis;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s), .dout_prev(line_p)
  );

  assign fall     = line_p & ~line_s;
  assign start_go = (state == ST_IDLE) && fall;

  srx_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .clr(start_go), .tick(tick)
  );

  assign pos_next = pos + 1'b1;
  assign wrap     = (pos_next == PW'(OSR));

  srx_vote #(.OSR(OSR), .PW(PW)) u_vote (
    .clk(clk), .rst(rst), .tick(tick), .pos_in(pos_next), .line(line_s),
    .decide(decide), .maj(maj), .dis(dis)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pos          <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      noise_acc    <= 1'b0;
      rx_valid     <= 1'b0;
      rx_byte      <= '0;
      rx_frame_err <= 1'b0;
      rx_noise_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) begin
            state     <= ST_START;
            pos       <= '0;
            noise_acc <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            pos <= wrap ? '0 : pos_next;
            if ((pos_next == PW'(MID)) && line_s) begin
              state <= ST_IDLE;
            end else if (wrap) begin
              state   <= ST_DATA;
              bit_idx <= '0;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            pos <= wrap ? '0 : pos_next;
            if (decide) begin
              shreg     <= {maj, shreg[DATA_BITS-1:1]};
              noise_acc <= noise_acc | dis;
            end
            if (wrap) begin
              if (bit_idx == BW'(DATA_BITS - 1)) state <= ST_STOP;
              else                               bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            pos <= wrap ? '0 : pos_next;
            if (decide) begin
              rx_valid     <= 1'b1;
              rx_byte      <= shreg;
              rx_frame_err <= ~maj;
              rx_noise_err <= noise_acc | dis;
              state        <= maj ? ST_IDLE : ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (line_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_valid,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_frame_err,
  input logic                 rx_noise_err,
  input srx_pkg::srx_state_e  state,
  input logic                 line_s
);
  import srx_pkg::*;

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_byte));

  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_frame_err));

  // R5
  noise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_noise_err));

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !line_s) |=> (state == ST_HOLD));
endmodule

bind serial_rx_vote srx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_frame_err(rx_frame_err), .rx_noise_err(rx_noise_err),
  .state(state), .line_s(line_s)
);

// File: tb/sim_serial_rx_vote.sv
`timescale 1ns/1ps
module sim_serial_rx_vote;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BITCLK     = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_frame_err, rx_noise_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_valid_cyc = 0;
  int run_len = 0;
  bit [9:0] got_q[$];

  serial_rx_vote #(.CLKS_PER_TICK(DIV)) u0 (
    .clk(clk), .rst(rst), .rx_line(rx), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_noise_err(rx_noise_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int q1 = 1, q2 = 1, q3 = 1;
  int mst = 0, mdiv = 0, mpos = 0, mbit = 0, msh = 0, mnoise = 0, mmaj = 0;
  int smp[3];
  int e_valid = 0, e_byte = 0, e_fe = 0, e_ne = 0;
  bit tk;

  always @(posedge clk) begin
    if (rst) begin
      q1 = 1; q2 = 1; q3 = 1; mst = 0; mdiv = 0; mpos = 0; mbit = 0;
      msh = 0; mnoise = 0; e_valid = 0; e_byte = 0; e_fe = 0; e_ne = 0;
    end else begin
      e_valid = 0;
      tk = 0;
      if (mst >= 1 && mst <= 3) begin
        if (mdiv == DIV - 1) begin tk = 1; mdiv = 0; end
        else mdiv++;
      end
      if (mst == 0) begin
        if (q3 == 1 && q2 == 0) begin mst = 1; mdiv = 0; mpos = 0; mnoise = 0; end
      end else if (mst == 4) begin
        if (q2 == 1) mst = 0;
      end else if (tk) begin
        mpos++;
        if (mpos >= 7 && mpos <= 9) smp[mpos-7] = q2;
        mmaj = ((smp[0] + smp[1] + smp[2]) >= 2) ? 1 : 0;
        if (mst == 1 && mpos == 8 && q2 == 1) mst = 0;
        else if (mst == 2 && mpos == 9) begin
          msh = (msh >> 1) | (mmaj << 7);
          if (!(smp[0] == smp[1] && smp[1] == smp[2])) mnoise = 1;
        end else if (mst == 3 && mpos == 9) begin
          e_valid = 1; e_byte = msh; e_fe = 1 - mmaj;
          e_ne = (mnoise != 0 || !(smp[0] == smp[1] && smp[1] == smp[2])) ? 1 : 0;
          mst = (mmaj == 1) ? 0 : 4;
        end
        if (mpos == 16) begin
          mpos = 0;
          if (mst == 1) begin mst = 2; mbit = 0; end
          else if (mst == 2) begin
            if (mbit == 7) mst = 3; else mbit++;
          end
        end
      end
      q3 = q2; q2 = q1; q1 = int'(rx);
    end
  end

  // per-cycle comparison and capture (R8: timing of every output)
  always @(negedge clk) begin
    if (!rst) begin
      chk(rx_valid == e_valid[0] && rx_byte == e_byte[7:0] &&
          rx_frame_err == e_fe[0] && rx_noise_err == e_ne[0],
          "R8 cycle model", {rx_valid, rx_frame_err, rx_noise_err, rx_byte},
          {e_valid[0], e_fe[0], e_ne[0], e_byte[7:0]});
      if (rx_valid) begin
        got_q.push_back({rx_frame_err, rx_noise_err, rx_byte});
        last_valid_cyc = cyc;
        run_len++;
      end else begin
        if (run_len != 0) chk(run_len == 1, "R8 valid width", run_len, 1);
        run_len = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n, input bit lvl = 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx = lvl;
    end
  endtask

  // glitch = sample index (ticks since the opening edge) to invert, -1 none
  task automatic send(input logic [7:0] b, input bit stopv, input int glitch,
                      output int start_cyc);
    for (int t = 0; t < 10 * BITCLK; t++) begin
      int idx;
      bit v;
      idx = t / BITCLK;
      v = (idx == 0) ? 1'b0 : (idx <= 8) ? b[idx-1] : stopv;
      if (glitch >= 0 && t == glitch * DIV) v = ~v;
      @(negedge clk);
      if (t == 0) start_cyc = cyc;
      rx = v;
    end
  endtask

  task automatic expect_char(input logic [7:0] b, input bit fe, input bit ne,
                             input string tag);
    bit [9:0] g;
    if (got_q.size() == 0) begin
      chk(1'b0, tag, 0, {fe, ne, b});
    end else begin
      g = got_q.pop_front();
      chk(g == {fe, ne, b}, tag, g, {fe, ne, b});
    end
  endtask

  initial begin
    int sc;
    rx = 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({rx_valid, rx_byte, rx_frame_err, rx_noise_err} == 0, "R1 reset", rx_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rx_valid, rx_byte, rx_frame_err, rx_noise_err} == 0, "R1 after reset", rx_byte, 0);
    idle(10);

    send(8'hA5, 1'b1, -1, sc); idle(20);
    expect_char(8'hA5, 0, 0, "R3 clean A5");
    chk(last_valid_cyc - sc == 153 * DIV + 3, "R8 latency", last_valid_cyc - sc, 153 * DIV + 3);

    send(8'h01, 1'b1, -1, sc); idle(20);
    expect_char(8'h01, 0, 0, "R3 lsb first 01");
    send(8'h80, 1'b1, -1, sc); idle(20);
    expect_char(8'h80, 0, 0, "R3 lsb first 80");

    send(8'h3C, 1'b1, 16 * 4 + 8, sc); idle(20);
    expect_char(8'h3C, 0, 1, "R4 R5 glitch data bit3 tick8");
    send(8'h5A, 1'b1, -1, sc); idle(20);
    expect_char(8'h5A, 0, 0, "R5 flag clears on clean char");
    send(8'hFF, 1'b1, 16 * 1 + 7, sc); idle(20);
    expect_char(8'hFF, 0, 1, "R4 R5 glitch bit0 tick7");
    send(8'h11, 1'b1, 16 * 9 + 9, sc); idle(20);
    expect_char(8'h11, 0, 1, "R5 glitch stop tick9");

    // runt start pulse: low through tick 7, high at tick 8
    idle(8 * DIV, 1'b0);
    idle(3 * BITCLK);
    chk(got_q.size() == 0, "R2 runt start rejected", got_q.size(), 0);
    send(8'hC3, 1'b1, -1, sc); idle(20);
    expect_char(8'hC3, 0, 0, "R2 recovery after runt");

    // framing error followed by a long low break
    send(8'h66, 1'b0, -1, sc);
    idle(12 * BITCLK, 1'b0);
    expect_char(8'h66, 1, 0, "R6 framing flag");
    chk(got_q.size() == 0, "R7 no char during break", got_q.size(), 0);
    idle(40);
    send(8'h99, 1'b1, -1, sc); idle(20);
    expect_char(8'h99, 0, 0, "R7 restart after line high");

    // back to back
    send(8'h12, 1'b1, -1, sc);
    send(8'h34, 1'b1, -1, sc);
    send(8'h56, 1'b1, 16 * 6 + 9, sc);
    idle(40);
    expect_char(8'h12, 0, 0, "R9 back-to-back 1");
    expect_char(8'h34, 0, 0, "R9 back-to-back 2");
    expect_char(8'h56, 0, 1, "R9 back-to-back 3");
    chk(got_q.size() == 0, "R9 no extra chars", got_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule